// File: doc/BRIEF.md
# Phase-Shifted Carrier Gate Generator for a Four-Cell Converter Arm

This block produces the switch commands for the four chopper cells of one arm of a modular multilevel converter. It uses phase-shifted carrier modulation. Each cell has its own triangular carrier, and every carrier covers the whole reference range. The carriers are spaced a quarter of a carrier period apart. A cell's upper switch turns on when the signed reference is strictly above that cell's carrier, and its lower switch always takes the opposite state. The arm voltage is the sum of four independent two-level decisions. It therefore steps through five levels, from all cells bypassed to all four inserted, and its effective switching rate is four times the carrier rate.

Each carrier is an up/down counter. It moves one step per clock between `-half_per` and `+half_per`, so a full carrier period lasts `4*half_per` clocks. The caller chooses `half_per` to match the frequency ratio it wants. For example, with a reference sample every clock, a ratio of 23 carrier periods per reference period needs a reference period of `92*half_per` clocks. The enable input restarts the four carriers from their quarter-period offsets. While the enable is low, the arm is held with every cell bypassed. Dead-time insertion and capacitor balancing belong to other blocks.

Each carrier runs a two-state machine. In state RISE the counter counts up. The transition RISE→FALL happens on the step that starts at or above `+half_per`. In state FALL the counter counts down. The transition FALL→RISE happens on the step that starts at or below `-half_per`. While the enable is low, the machine is forced into the start state of its own phase slot, and its count is forced to the start value of that slot.

Top module: `psc_gate_gen`

## Requirements
- R1: On the first clock edge with `arm_en` high after a clock edge with it low, the carriers of cells 0, 1, 2 and 3 are compared at their start values. These values are -H, 0, +H and 0, where H is `half_per`. Cells 0 and 1 then count upward, and cells 2 and 3 count downward.
- R2: Each carrier moves by exactly one per clock while enabled. It reverses direction on the step that starts at +H or above (the next value is one less) and on the step that starts at -H or below (the next value is one more). With H constant, it stays within [-H, +H] and repeats every 4H clocks.
- R3: On each enabled edge, top gate bit i (`top_g[i]`, cell i) is set to 1 if `ref_in` is strictly greater than carrier i, and cleared to 0 if it is strictly smaller. `ref_in` is a two's-complement value.
- R4: On an enabled edge where `ref_in` equals carrier i, `top_g[i]` keeps its previous value.
- R5: `bot_g[i]` is always the inverse of `top_g[i]`, for every cell.
- R6: `n_ins` is the number of ones in `top_g`, as an unsigned value from 0 to 4.
- R7: A clock edge with `arm_en` low clears every top gate, which sets every bottom gate. It also reloads the start values of R1 from the current H, so the next enabled run starts from the same phase offsets.
- R8: Reset (`rst` high at a clock edge) clears every top gate and sets the count to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register samples on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| arm_en | input | 1 | Run enable; low bypasses all cells and re-arms the phase offsets |
| half_per | input | REF_W-1 | Carrier peak H; one carrier period is 4H clocks (H >= 1) |
| ref_in | input | REF_W | Signed reference sample |
| top_g | output | 4 | Upper-switch commands, bit i for cell i, 1 = on |
| bot_g | output | 4 | Lower-switch commands, inverse of `top_g` |
| n_ins | output | 3 | Number of inserted cells, 0 to 4 |

## Verification
Several properties are checked on every cycle. Each carrier stays bounded while H is stable. The carriers reload their slot start values after a disabled edge. A cell's gate follows the strict comparison and holds on equality. The arm is fully bypassed after any disabled edge, and the count matches the gates. Only the bench scenarios can show the relative quarter-period spacing of the four carriers and the periodicity of the gate pattern. The same applies to restart after re-enable and to saturation when the reference lies outside the carrier range. For these, the bench compares cycle by cycle against a model built from the requirements and also checks hand-worked start-up values.

// File: rtl/psc_pkg.sv
package psc_pkg;

    localparam int NUM_SM = 4;
    localparam int CNT_W  = $clog2(NUM_SM + 1);

    typedef enum logic {
        C_RISE = 1'b0,
        C_FALL = 1'b1
    } car_dir_e;

    // Quarter slot q: 0 -> bottom rising, 1 -> mid rising,
    // 2 -> top falling, 3 -> mid falling.
    function automatic car_dir_e slot_dir(input int q);
        return (q < 2) ? C_RISE : C_FALL;
    endfunction

endpackage

// File: rtl/psc_carrier.sv
module psc_carrier
    import psc_pkg::*;
#(
    parameter int REF_W = 12,
    parameter int SLOT  = 0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic [REF_W-2:0]        half,
    output logic signed [REF_W-1:0] val
);
    localparam int HALF_W = REF_W - 1;

    car_dir_e                 st_q, st_d;
    logic signed [REF_W-1:0]  val_d;
    logic signed [REF_W-1:0]  pk_pos, pk_neg, start_val;

    always_comb begin
        pk_pos = signed'({1'b0, half});
        pk_neg = -pk_pos;
        if (SLOT == 0)      start_val = pk_neg;
        else if (SLOT == 2) start_val = pk_pos;
        else                start_val = '0;
    end

    // next-state and next-count
    always_comb begin
        st_d  = st_q;
        val_d = val;
        if (!en) begin
            st_d  = slot_dir(SLOT);
            val_d = start_val;
        end else begin
            unique case (st_q)
                C_RISE: begin
                    if (val >= pk_pos) begin
                        st_d  = C_FALL;
                        val_d = val - 1'b1;
                    end else begin
                        val_d = val + 1'b1;
                    end
                end
                C_FALL: begin
                    if (val <= pk_neg) begin
                        st_d  = C_RISE;
                        val_d = val + 1'b1;
                    end else begin
                        val_d = val - 1'b1;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= C_RISE;
            val  <= '0;
        end else begin
            st_q <= st_d;
            val  <= val_d;
        end
    end

    // R2: bounded while H is stable and the count was in range
    a_r2_carrier_bounded: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(en) && $stable(half)
         && $past(val) <= $past(pk_pos) && $past(val) >= $past(pk_neg))
        |-> (val <= pk_pos && val >= pk_neg));

    // R2: one step per enabled clock
    a_r2_unit_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(en))
        |-> (val == $past(val) + 1 || val == $past(val) - 1));

    // R1/R7: disabled edge reloads the slot start value
    a_r1_reload_start: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(en)) |-> (val == $past(start_val)));

    initial begin
        a_r1_slot_range: assert (SLOT >= 0 && SLOT < NUM_SM && HALF_W >= 1);
    end

endmodule

// File: rtl/psc_compare.sv
module psc_compare #(
    parameter int REF_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic signed [REF_W-1:0] ref_in,
    input  logic signed [REF_W-1:0] car,
    output logic                    gate
);
    logic gate_d;

    always_comb begin
        gate_d = gate;
        if (!en)               gate_d = 1'b0;
        else if (ref_in > car) gate_d = 1'b1;
        else if (ref_in < car) gate_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) gate <= 1'b0;
        else     gate <= gate_d;
    end

    a_r3_above_sets: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(en) && $past(ref_in > car)) |-> gate);

    a_r3_below_clears: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(en) && $past(ref_in < car)) |-> !gate);

    a_r4_equal_holds: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(en) && $past(ref_in == car)) |-> (gate == $past(gate)));

endmodule

// File: rtl/psc_popcount.sv
module psc_popcount
    import psc_pkg::*;
(
    input  logic [NUM_SM-1:0] bits_in,
    output logic [CNT_W-1:0]  ones
);
    always_comb begin
        ones = '0;
        for (int i = 0; i < NUM_SM; i++) begin
            ones = ones + CNT_W'(bits_in[i]);
        end
    end
endmodule

// File: rtl/psc_gate_gen.sv
module psc_gate_gen
    import psc_pkg::*;
#(
    parameter int REF_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    arm_en,
    input  logic [REF_W-2:0]        half_per,
    input  logic signed [REF_W-1:0] ref_in,
    output logic [NUM_SM-1:0]       top_g,
    output logic [NUM_SM-1:0]       bot_g,
    output logic [CNT_W-1:0]        n_ins
);
    logic signed [REF_W-1:0] car [NUM_SM];
    logic [NUM_SM-1:0]       gate_q;

    for (genvar g = 0; g < NUM_SM; g++) begin : g_cell
        psc_carrier #(.REF_W(REF_W), .SLOT(g)) u_car (
            .clk  (clk),
            .rst  (rst),
            .en   (arm_en),
            .half (half_per),
            .val  (car[g])
        );
        psc_compare #(.REF_W(REF_W)) u_cmp (
            .clk    (clk),
            .rst    (rst),
            .en     (arm_en),
            .ref_in (ref_in),
            .car    (car[g]),
            .gate   (gate_q[g])
        );
    end

    psc_popcount u_cnt (
        .bits_in (gate_q),
        .ones    (n_ins)
    );

    always_comb begin
        top_g = gate_q;
        bot_g = ~gate_q;
    end

    // R7: any disabled edge leaves every cell bypassed
    a_r7_disabled_bypass: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(arm_en)) |-> (top_g == '0 && n_ins == '0));

    // R6: count never exceeds the cell count and tracks inserted cells
    a_r6_count_matches: assert property (@(posedge clk) disable iff (rst)
        (n_ins <= CNT_W'(NUM_SM)) && (32'(n_ins) == $countones(top_g)));

    // R5: each pair is complementary
    a_r5_pairs_opposed: assert property (@(posedge clk) disable iff (rst)
        (top_g & bot_g) == '0 && (top_g | bot_g) == '1);

    // R8: reset leaves all cells bypassed
    a_r8_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (top_g == '0));

endmodule

// File: tb/psc_gate_gen_bench.sv
module psc_gate_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int REF_W = 12;
    localparam int NSEG = 8;
    localparam int SEG_EN  [NSEG] = '{1, 1, 1, 0, 1, 1, 1, 1};
    localparam int SEG_REF [NSEG] = '{0, 2, -3, 1, 5, -2, 7, -8};
    localparam int SEG_H   [NSEG] = '{4, 4, 4, 6, 6, 6, 6, 6};
    localparam int SEG_LEN [NSEG] = '{20, 17, 9, 3, 30, 25, 11, 7};

    logic clk = 1'b0;
    logic rst;
    logic arm_en;
    logic [REF_W-2:0] half_per;
    logic signed [REF_W-1:0] ref_in;
    logic [3:0] top_g, bot_g;
    logic [2:0] n_ins;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    int mc [4];
    bit md [4];
    bit mg [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    psc_gate_gen #(.REF_W(REF_W)) u_psc_gate_gen (
        .clk(clk), .rst(rst), .arm_en(arm_en), .half_per(half_per),
        .ref_in(ref_in), .top_g(top_g), .bot_g(bot_g), .n_ins(n_ins)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int m_top();
        int v = 0;
        for (int i = 0; i < 4; i++) v |= int'(mg[i]) << i;
        return v;
    endfunction

    // model of one clock edge from the requirements
    task automatic model_edge();
        int h = int'(half_per);
        int r = int'(ref_in);
        for (int i = 0; i < 4; i++) begin
            if (!arm_en) begin
                mg[i] = 0;
                mc[i] = (i == 0) ? -h : (i == 2) ? h : 0;
                md[i] = (i >= 2);
            end else begin
                if (r > mc[i]) mg[i] = 1;
                else if (r < mc[i]) mg[i] = 0;
                if (!md[i]) begin
                    if (mc[i] >= h) begin mc[i]--; md[i] = 1; end
                    else mc[i]++;
                end else begin
                    if (mc[i] <= -h) begin mc[i]++; md[i] = 0; end
                    else mc[i]--;
                end
            end
        end
    endtask

    task automatic step_and_check();
        int pop = 0;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        for (int i = 0; i < 4; i++) pop += int'(mg[i]);
        check("R3/R4 top_g", int'(top_g), m_top());
        check("R5 bot_g", int'(bot_g), (~m_top()) & 15);
        check("R6 n_ins", int'(n_ins), pop);
    endtask

    task automatic idle_edge();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; arm_en = 1'b0; half_per = 11'd4; ref_in = '0;
        for (int i = 0; i < 4; i++) begin mc[i] = 0; md[i] = 0; mg[i] = 0; end
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 top_g after reset", int'(top_g), 0);
        check("R8 bot_g after reset", int'(bot_g), 15);
        check("R8 n_ins after reset", int'(n_ins), 0);
        rst = 1'b0;
        idle_edge();

        // table walk: model-compared, covers R2 periodicity, R3, R4, R7
        for (int s = 0; s < NSEG; s++) begin
            arm_en   = SEG_EN[s][0];
            half_per = 11'(SEG_H[s]);
            ref_in   = 12'(SEG_REF[s]);
            for (int k = 0; k < SEG_LEN[s]; k++) step_and_check();
        end

        // R1 directed: H=4, ref=0, fresh start
        arm_en = 1'b0; half_per = 11'd4; ref_in = '0;
        step_and_check();
        check("R7 disabled top_g", int'(top_g), 0);
        check("R7 disabled bot_g", int'(bot_g), 15);
        arm_en = 1'b1;
        step_and_check();
        check("R1 first enabled edge top_g", int'(top_g), 4'b0001);
        check("R4 equal keeps low n_ins", int'(n_ins), 1);
        step_and_check();
        check("R1 second enabled edge top_g", int'(top_g), 4'b1001);
        check("R6 second edge n_ins", int'(n_ins), 2);

        // R2: gate pattern repeats with period 4H (H=4 -> 16 clocks)
        begin
            int pat [16];
            for (int k = 0; k < 16; k++) begin step_and_check(); pat[k] = int'(top_g); end
            for (int k = 0; k < 16; k++) begin
                step_and_check();
                check("R2 period 4H repeat", int'(top_g), pat[k]);
            end
        end

        // R7 restart: drop enable one edge, then same start pattern
        arm_en = 1'b0;
        step_and_check();
        check("R7 bypass on disable", int'(n_ins), 0);
        arm_en = 1'b1;
        step_and_check();
        check("R7 restart phase top_g", int'(top_g), 4'b0001);

        // R3 saturation: reference outside the carrier range
        ref_in = 12'sd5;
        for (int k = 0; k < 10; k++) step_and_check();
        check("R3 ref above range n_ins", int'(n_ins), 4);
        ref_in = -12'sd5;
        step_and_check();
        check("R3 ref below range top_g", int'(top_g), 0);
        check("R5 ref below range bot_g", int'(bot_g), 15);

        // R8: reset in the middle of a run
        ref_in = 12'sd5;
        for (int k = 0; k < 3; k++) step_and_check();
        rst = 1'b1;
        idle_edge();
        check("R8 mid-run reset top_g", int'(top_g), 0);
        rst = 1'b0; arm_en = 1'b0;
        idle_edge();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule